// File: doc/BRIEF.md
# Programmable AND-OR Product-Term Plane

This block is the logic plane of a small programmable array. Twenty logic inputs reach it: twelve dedicated inputs (the last of which doubles as the shared clock pin) and eight feedback lines from the output cells. Each input appears in true and inverted form, so every product term sees forty lines. Ninety product terms are formed. Eighty of them are ORed into eight sum outputs, with twelve terms behind each of the first four outputs and eight behind each of the last four. Eight more terms act as per-output enables. The final two act as the global asynchronous set and clear terms.

Each product term is configured by one 40-bit row. The row is written through a plain address, data and write-enable port and held in flops. Evaluation from inputs and stored rows to every output is purely combinational. A row write takes effect after the clock edge that captures it. The cells that consume these terms are a separate block.

Top module: `pterm_plane`

## Requirements
- R1: An active-low asynchronous reset sets every stored row to all-zero (every pair inactive), so after reset every sum, enable, set and clear output is 0 for any input values.
- R2: With `cfg_we` high at a rising clock edge and `cfg_addr` in 0..89, row `cfg_addr` becomes `cfg_row` and is reflected at the outputs from that edge on. A later write to the same row replaces the earlier one.
- R3: A write with `cfg_addr` of 90 or more changes no stored row, so no output changes because of it.
- R4: Input index i is `ded_in[i]` for i in 0..11 and `fb_in[i-12]` for i in 12..19. Row bits [2i+1:2i] hold the link pair for input i: 2'b01 selects the true input, 2'b10 the inverted input, 2'b11 ignores the input, and 2'b00 is inactive.
- R5: A product term is the AND, over all 20 inputs, of the value each pair selects. Any inactive pair forces the term to 0, and a row of all 2'b11 pairs gives 1.
- R6: Sum output o for o in 0..3 is the OR of rows 12*o to 12*o+11. Sum output o for o in 4..7 is the OR of rows 48+8*(o-4) to 55+8*(o-4).
- R7: `oe_term[o]` is the term of row 80+o, `preset_term` is row 88 and `clear_term` is row 89.
- R8: Outputs follow input changes within the same cycle, with no clock edge in between.
- R9: An enable, set or clear term with even one inactive pair is low, whatever the other pairs and inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for row writes |
| rst_n | input | 1 | Asynchronous active-low reset of the row store |
| cfg_we | input | 1 | Row write enable |
| cfg_addr | input | 7 | Row index to write |
| cfg_row | input | 40 | Row contents, two bits per input |
| ded_in | input | 12 | Dedicated inputs; bit 11 is the shared clock/input pin |
| fb_in | input | 8 | Feedback lines from the output cells |
| sum_out | output | 8 | ORed product-term sums, one per output |
| oe_term | output | 8 | Per-output enable terms |
| preset_term | output | 1 | Global asynchronous set term |
| clear_term | output | 1 | Global asynchronous clear term |

## Verification
The bench targets the group edges: rows 11/12, 47/48 and 79/80. An off-by-one slice would move a term into the wrong sum or into an enable. It writes to addresses 90 and 127 with all-ignore rows, which would raise outputs if the address were truncated or wrapped. It places one inactive pair in an otherwise all-ignore row, which catches a decoder that treats 2'b00 like 2'b11. It also changes inputs between writes and checks before any further edge, so a design that registers its outputs shows stale values.

// File: rtl/pt_plane_pkg.sv
package pt_plane_pkg;

    typedef enum logic [1:0] {
        LINK_OPEN = 2'b00,
        LINK_TRUE = 2'b01,
        LINK_COMP = 2'b10,
        LINK_ANY  = 2'b11
    } link_t;

endpackage

// File: rtl/pt_fuse_store.sv
module pt_fuse_store #(
    parameter int ROWS   = 90,
    parameter int ROW_W  = 40,
    parameter int ADDR_W = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [ROW_W-1:0]           wr_row,
    output logic [ROWS-1:0][ROW_W-1:0] rows_o
);

    localparam logic [ADDR_W-1:0] LAST_ROW = ADDR_W'(ROWS - 1);

    typedef struct packed {
        logic [ROWS-1:0][ROW_W-1:0] rows;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        for (int r = 0; r < ROWS; r++) begin
            if (wr_en && wr_addr == ADDR_W'(r)) begin
                store_d.rows[r] = wr_row;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign rows_o = store_q.rows;

    // R2: an in-range write lands in the addressed row on the next edge
    p_row_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr <= LAST_ROW) |=> rows_o[$past(wr_addr)] == $past(wr_row));

    // R3: no in-range write means the whole store holds
    p_oob_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr <= LAST_ROW) |=> $stable(store_q));

endmodule

// File: rtl/pt_term_eval.sv
module pt_term_eval
    import pt_plane_pkg::*;
#(
    parameter int NIN  = 20,
    parameter int ROWS = 90
) (
    input  logic [NIN-1:0]               in_vec,
    input  logic [ROWS-1:0][2*NIN-1:0]   rows,
    output logic [ROWS-1:0]              terms
);

    for (genvar t = 0; t < ROWS; t++) begin : g_term
        logic hit;
        always_comb begin
            hit = 1'b1;
            for (int i = 0; i < NIN; i++) begin
                case (link_t'(rows[t][2*i +: 2]))
                    LINK_OPEN: hit = 1'b0;
                    LINK_TRUE: hit = hit & in_vec[i];
                    LINK_COMP: hit = hit & ~in_vec[i];
                    LINK_ANY:  hit = hit;
                    default:   hit = 1'b0;
                endcase
            end
        end
        assign terms[t] = hit;
    end

endmodule

// File: rtl/pt_or_group.sv
module pt_or_group #(
    parameter int OUTS      = 8,
    parameter int WIDE_OUTS = 4,
    parameter int WIDE_N    = 12,
    parameter int NARROW_N  = 8,
    localparam int SUM_ROWS = WIDE_OUTS * WIDE_N + (OUTS - WIDE_OUTS) * NARROW_N
) (
    input  logic [SUM_ROWS-1:0] terms,
    output logic [OUTS-1:0]     sums
);

    for (genvar o = 0; o < OUTS; o++) begin : g_out
        if (o < WIDE_OUTS) begin : g_wide
            localparam int BASE = o * WIDE_N;
            assign sums[o] = |terms[BASE +: WIDE_N];
        end else begin : g_narrow
            localparam int BASE = WIDE_OUTS * WIDE_N + (o - WIDE_OUTS) * NARROW_N;
            assign sums[o] = |terms[BASE +: NARROW_N];
        end
    end

endmodule

// File: rtl/pterm_plane.sv
module pterm_plane #(
    parameter int NUM_DED   = 12,
    parameter int NUM_FB    = 8,
    parameter int WIDE_OUTS = 4,
    parameter int WIDE_N    = 12,
    parameter int NARROW_N  = 8,
    parameter int ADDR_W    = 7,
    localparam int NIN      = NUM_DED + NUM_FB,
    localparam int ROW_W    = 2 * NIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic [NUM_DED-1:0] ded_in,
    input  logic [NUM_FB-1:0] fb_in,
    output logic [NUM_FB-1:0] sum_out,
    output logic [NUM_FB-1:0] oe_term,
    output logic              preset_term,
    output logic              clear_term
);

    localparam int SUM_ROWS = WIDE_OUTS * WIDE_N + (NUM_FB - WIDE_OUTS) * NARROW_N;
    localparam int OE_BASE  = SUM_ROWS;
    localparam int PRE_ROW  = OE_BASE + NUM_FB;
    localparam int CLR_ROW  = PRE_ROW + 1;
    localparam int ROWS     = CLR_ROW + 1;

    logic [ROWS-1:0][ROW_W-1:0] rows;
    logic [ROWS-1:0]            terms;
    logic [NIN-1:0]             in_vec;

    assign in_vec = {fb_in, ded_in};

    pt_fuse_store #(.ROWS(ROWS), .ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_row  (cfg_row),
        .rows_o  (rows)
    );

    pt_term_eval #(.NIN(NIN), .ROWS(ROWS)) u_eval (
        .in_vec (in_vec),
        .rows   (rows),
        .terms  (terms)
    );

    pt_or_group #(
        .OUTS(NUM_FB), .WIDE_OUTS(WIDE_OUTS), .WIDE_N(WIDE_N), .NARROW_N(NARROW_N)
    ) u_or (
        .terms (terms[SUM_ROWS-1:0]),
        .sums  (sum_out)
    );

    assign oe_term     = terms[OE_BASE +: NUM_FB];
    assign preset_term = terms[PRE_ROW];
    assign clear_term  = terms[CLR_ROW];

    function automatic logic has_open(input logic [ROW_W-1:0] r);
        logic found;
        found = 1'b0;
        for (int i = 0; i < NIN; i++) begin
            if (r[2*i +: 2] == 2'b00) found = 1'b1;
        end
        return found;
    endfunction

    // R1: first cycle out of reset, every output is low
    p_reset_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sum_out == '0 && oe_term == '0 && !preset_term && !clear_term));

    // R6: a sum can only be high if some sum-group term is high
    p_sum_from_terms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|sum_out) |-> (|terms[SUM_ROWS-1:0]));

    // R9: set and clear stay low while their rows hold an inactive pair
    p_preset_open_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        preset_term |-> !has_open(rows[PRE_ROW]));

    p_clear_open_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_term |-> !has_open(rows[CLR_ROW]));

endmodule

// File: tb/pterm_plane_test.sv
module pterm_plane_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [39:0] cfg_row = '0;
    logic [11:0] ded_in = '0;
    logic [7:0]  fb_in = '0;
    logic [7:0]  sum_out;
    logic [7:0]  oe_term;
    logic        preset_term;
    logic        clear_term;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [39:0] shadow [90];

    typedef struct {
        string       tag;
        logic [7:0]  s;
        logic [7:0]  oe;
        logic        p;
        logic        c;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pterm_plane uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_row     (cfg_row),
        .ded_in      (ded_in),
        .fb_in       (fb_in),
        .sum_out     (sum_out),
        .oe_term     (oe_term),
        .preset_term (preset_term),
        .clear_term  (clear_term)
    );

    // Reference from the requirements: pair codes per R4, AND per R5
    function automatic logic model_term(logic [39:0] r, logic [19:0] v);
        logic res;
        res = 1'b1;
        for (int i = 0; i < 20; i++) begin
            case (r[2*i +: 2])
                2'b00: res = 1'b0;
                2'b01: res = res & v[i];
                2'b10: res = res & ~v[i];
                default: res = res;
            endcase
        end
        return res;
    endfunction

    function automatic logic [39:0] row_with(logic [39:0] base, int idx, logic [1:0] code);
        logic [39:0] r;
        r = base;
        r[2*idx +: 2] = code;
        return r;
    endfunction

    task automatic write_row(int a, logic [39:0] r);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 7'(a);
        cfg_row = r;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (a < 90) shadow[a] = r;
    endtask

    // Driver: drive inputs, push expected outputs built from R6/R7 layout
    task automatic apply(logic [11:0] d, logic [7:0] f, string tag);
        exp_t e;
        logic [19:0] v;
        @(posedge clk);
        #1;
        ded_in = d;
        fb_in = f;
        v = {f, d};
        e.tag = tag;
        e.s = '0;
        for (int o = 0; o < 8; o++) begin
            int base;
            int n;
            base = (o < 4) ? 12*o : 48 + 8*(o-4);
            n = (o < 4) ? 12 : 8;
            for (int k = 0; k < n; k++) begin
                if (model_term(shadow[base+k], v)) e.s[o] = 1'b1;
            end
            e.oe[o] = model_term(shadow[80+o], v);
        end
        e.p = model_term(shadow[88], v);
        e.c = model_term(shadow[89], v);
        exp_q.push_back(e);
    endtask

    // Monitor: compare away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (sum_out !== e.s || oe_term !== e.oe || preset_term !== e.p || clear_term !== e.c) begin
                    fails++;
                    $display("FAIL %s: got sum=%b oe=%b set=%b clr=%b, expected sum=%b oe=%b set=%b clr=%b",
                             e.tag, sum_out, oe_term, preset_term, clear_term, e.s, e.oe, e.p, e.c);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [39:0] any_row;
        any_row = {40{1'b1}};
        for (int i = 0; i < 90; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all rows inactive after reset, even with all inputs high
        apply(12'hFFF, 8'hFF, "R1 reset state");

        // R3: writes past the last row must not land anywhere
        write_row(90, any_row);
        write_row(127, any_row);
        apply(12'hFFF, 8'hFF, "R3 out-of-range writes ignored");
        apply(12'h000, 8'h00, "R3 out-of-range writes ignored, inputs low");

        // R4/R2: row 0 true on input 0
        write_row(0, row_with(any_row, 0, 2'b01));
        apply(12'h001, 8'h00, "R4 true link high");
        apply(12'h000, 8'h00, "R8 same-cycle input change, R4 true link low");

        // R6/R4: last row of output 3 uses inverted feedback 3 (input 15)
        write_row(47, row_with(any_row, 15, 2'b10));
        apply(12'h000, 8'h00, "R4 complement link on feedback");
        apply(12'h000, 8'h08, "R6 row 47 belongs to output 3");

        // R6: row 11 stays in output 0, shared input 11 true
        write_row(11, row_with(any_row, 11, 2'b01));
        apply(12'h800, 8'h08, "R6 row 11 belongs to output 0");

        // R5: all-ignore row in output 4; R6: row 79 in output 7
        write_row(48, any_row);
        write_row(79, row_with(any_row, 19, 2'b01));
        apply(12'h000, 8'h80, "R5 all-ignore term, R6 rows 48 and 79");
        apply(12'h000, 8'h00, "R6 row 79 tracks feedback 7");

        // R5: one inactive pair kills the term in output 1
        write_row(12, row_with(any_row, 5, 2'b00));
        apply(12'hFFF, 8'hFF, "R5 inactive pair forces term low");

        // R7: enable 2 from row 82
        write_row(82, row_with(row_with(any_row, 2, 2'b01), 14, 2'b10));
        apply(12'h004, 8'h00, "R7 enable term high");
        apply(12'h004, 8'h04, "R7 enable term low via complement");

        // R7: set term all ignore; R9: clear term with one inactive pair
        write_row(88, any_row);
        write_row(89, row_with(any_row, 7, 2'b00));
        apply(12'h0A5, 8'h3C, "R7 set term, R9 clear term held low");

        // R9/R2: overwrite set row with an inactive pair
        write_row(88, row_with(any_row, 19, 2'b00));
        apply(12'hFFF, 8'hFF, "R9 set term low after overwrite, R2 rewrite");
        apply(12'h555, 8'hAA, "R8 mixed inputs");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule